// File: doc/BRIEF.md
# Transmit Inter-Packet Gap Deferral Controller

This block tells an Ethernet-style MAC transmitter when it may begin its next frame. It produces one registered level, `tx_permit`. The level drops as soon as a frame begins. It rises again once the spacing rule for the current duplex mode has been met. Time is measured in nibble ticks, where one tick stands for four bit-times.

In full-duplex operation the spacing is a programmable minimum counted from the end of the previous transmission. The programmed value is given in byte-times, and each byte-time is two ticks. In half-duplex operation the line itself is the reference. The block needs 96 bit-times (24 ticks) of continuous carrier absence, counted from the moment carrier sense falls, and the backoff logic must also report that its delay has finished.

Top module: `tx_gap_defer`

## Requirements
- R1: While reset is applied, `tx_permit` is 0. After reset the gap counter starts at zero, so a full gap must elapse before the first permit.
- R2: A cycle with `tx_begin` high clears `tx_permit` at the next clock edge.
- R3: Ticks that arrive between `tx_begin` and `tx_done` are not counted. Gap counting starts from zero after `tx_done`.
- R4: In full duplex, with a gap setting G from 8 to 27, `tx_permit` stays 0 for the first 2*G-1 ticks after `tx_done`. It rises on the clock edge that follows the edge sampling tick number 2*G.
- R5: A full-duplex gap setting below 8 behaves exactly like 8, which means 16 ticks.
- R6: A full-duplex gap setting above 27 (the 5-bit field reaches 31) behaves exactly like 27, which means 54 ticks.
- R7: In half duplex, with backoff complete, `tx_permit` rises after 24 ticks with `carrier_sense` low. It stays 0 after 23 such ticks.
- R8: In half duplex, `carrier_sense` high clears `tx_permit` at the next edge and resets the idle count. Counting restarts from zero once carrier sense drops again.
- R9: In half duplex, `tx_permit` stays 0 while `backoff_done` is 0, even after the idle gap has elapsed. It rises one edge after `backoff_done` goes high.
- R10: In full duplex, `carrier_sense` and `backoff_done` have no effect on the gap count or on `tx_permit`.
- R11: Once set, `tx_permit` stays high until the next `tx_begin`, as long as the mode and the settings are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| nib_tick | input | 1 | One-cycle pulse per nibble time (4 bit-times) |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| gap_bytes | input | 5 | Full-duplex minimum gap in byte-times, clamped to 8..27 |
| tx_begin | input | 1 | One-cycle pulse when a frame starts transmitting |
| tx_done | input | 1 | One-cycle pulse when the frame's last nibble has been sent |
| carrier_sense | input | 1 | Line activity from the PHY |
| backoff_done | input | 1 | High when no backoff delay is outstanding |
| tx_permit | output | 1 | Registered level: a new frame may start |

## Verification
The checker assumes well-formed framing. Every `tx_done` follows a `tx_begin`, the two are never high in the same cycle, and `full_duplex` and `gap_bytes` change only while a frame is in progress. The bench follows these rules by setting the mode and the gap between the begin and done pulses of a frame. Every tick is a single-cycle pulse followed by an idle cycle, so the exact edge at which the permit rises can be predicted.

// File: rtl/tx_gap_pkg.sv
package tx_gap_pkg;

  typedef enum logic {
    DUPLEX_HALF = 1'b0,
    DUPLEX_FULL = 1'b1
  } duplex_e;

  // Saturate a value into [lo, hi].
  function automatic int unsigned clamp_u(input int unsigned v,
                                          input int unsigned lo,
                                          input int unsigned hi);
    if (v < lo)      return lo;
    else if (v > hi) return hi;
    else             return v;
  endfunction

endpackage

// File: rtl/tx_gap_rst_sync.sv
module tx_gap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/tx_gap_target.sv
module tx_gap_target
  import tx_gap_pkg::*;
#(
  parameter int GAP_W          = 5,
  parameter int CNT_W          = 6,
  parameter int MIN_B          = 8,
  parameter int MAX_B          = 27,
  parameter int TICKS_PER_BYTE = 2,
  parameter int IDLE_TICKS     = 24
) (
  input  logic             full_duplex,
  input  logic [GAP_W-1:0] gap_bytes,
  output logic [CNT_W-1:0] target
);

  logic [CNT_W-1:0] fd_target;
  logic [CNT_W-1:0] hd_target;

  always_comb begin
    int unsigned clamped;
    clamped   = clamp_u(int'(gap_bytes), MIN_B, MAX_B);
    fd_target = CNT_W'(clamped * TICKS_PER_BYTE);
    hd_target = CNT_W'(IDLE_TICKS);
    target    = (duplex_e'(full_duplex) == DUPLEX_FULL) ? fd_target : hd_target;
  end

endmodule

// File: rtl/tx_gap_counter.sv
module tx_gap_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] target,
  output logic             reached
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    reached = (cnt_q >= target);
    cnt_en  = clr || (tick && !reached);
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/tx_gap_defer.sv
module tx_gap_defer #(
  parameter int GAP_W     = 5,
  parameter int CNT_W     = 6,
  parameter int MIN_B     = 8,
  parameter int MAX_B     = 27,
  parameter int IDLE_BITS = 96,
  parameter int TICK_BITS = 4,
  parameter int SYNC_STG  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nib_tick,
  input  logic             full_duplex,
  input  logic [GAP_W-1:0] gap_bytes,
  input  logic             tx_begin,
  input  logic             tx_done,
  input  logic             carrier_sense,
  input  logic             backoff_done,
  output logic             tx_permit
);

  localparam int TICKS_PER_BYTE = 8 / TICK_BITS;
  localparam int IDLE_TICKS     = IDLE_BITS / TICK_BITS;

  logic             rst_i_n;
  logic [CNT_W-1:0] target;
  logic             reached;
  logic             cnt_clr;
  logic             hd_busy_line;
  logic             busy_q, busy_d, busy_en;
  logic             permit_q, permit_d, permit_en;

  tx_gap_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  tx_gap_target #(
    .GAP_W          (GAP_W),
    .CNT_W          (CNT_W),
    .MIN_B          (MIN_B),
    .MAX_B          (MAX_B),
    .TICKS_PER_BYTE (TICKS_PER_BYTE),
    .IDLE_TICKS     (IDLE_TICKS)
  ) u_target (
    .full_duplex (full_duplex),
    .gap_bytes   (gap_bytes),
    .target      (target)
  );

  tx_gap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .clr     (cnt_clr),
    .tick    (nib_tick),
    .target  (target),
    .reached (reached)
  );

  // Next-state logic
  always_comb begin
    hd_busy_line = !full_duplex && carrier_sense;
    cnt_clr      = busy_q || tx_begin || tx_done || hd_busy_line;

    busy_en = tx_begin || tx_done;
    busy_d  = tx_begin;

    permit_d  = !busy_q && !tx_begin && reached &&
                (full_duplex || (backoff_done && !carrier_sense));
    permit_en = (permit_d != permit_q);
  end

  // State registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      busy_q   <= 1'b0;
      permit_q <= 1'b0;
    end else begin
      if (busy_en)   busy_q   <= busy_d;
      if (permit_en) permit_q <= permit_d;
    end
  end

  assign tx_permit = permit_q;

endmodule

// File: rtl/tx_gap_defer_chk.sv
module tx_gap_defer_chk #(
  parameter int GAP_W     = 5,
  parameter int MIN_B     = 8,
  parameter int IDLE_BITS = 96,
  parameter int TICK_BITS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             nib_tick,
  input logic             full_duplex,
  input logic [GAP_W-1:0] gap_bytes,
  input logic             tx_begin,
  input logic             tx_done,
  input logic             carrier_sense,
  input logic             backoff_done,
  input logic             tx_permit
);

  localparam int MIN_TICKS  = MIN_B * (8 / TICK_BITS);
  localparam int IDLE_TICKS = IDLE_BITS / TICK_BITS;

  // Independent tick tallies, saturating at 63.
  logic [5:0] ticks_since_frame;
  logic [5:0] ticks_since_carrier;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ticks_since_frame   <= '0;
      ticks_since_carrier <= '0;
    end else begin
      if (tx_begin || tx_done)               ticks_since_frame <= '0;
      else if (nib_tick && ticks_since_frame != 6'd63)
        ticks_since_frame <= ticks_since_frame + 6'd1;
      if (tx_begin || tx_done || carrier_sense) ticks_since_carrier <= '0;
      else if (nib_tick && ticks_since_carrier != 6'd63)
        ticks_since_carrier <= ticks_since_carrier + 6'd1;
    end
  end

  AST_BEGIN_DROPS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_begin |=> !tx_permit); // R2

  AST_HD_CARRIER_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_duplex && carrier_sense) |=> !tx_permit); // R8

  AST_HD_BACKOFF_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_duplex && !backoff_done) |=> !tx_permit); // R9

  AST_GAP_AT_LEAST_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_permit) |-> (ticks_since_frame >= 6'(MIN_TICKS))); // R4

  AST_HD_IDLE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_permit) && !full_duplex) |-> (ticks_since_carrier >= 6'(IDLE_TICKS))); // R7

  AST_PERMIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_permit && full_duplex && !tx_begin && !tx_done &&
     $stable(gap_bytes) && $stable(full_duplex)) |=> tx_permit); // R11

endmodule

bind tx_gap_defer tx_gap_defer_chk #(
  .GAP_W     (GAP_W),
  .MIN_B     (MIN_B),
  .IDLE_BITS (IDLE_BITS),
  .TICK_BITS (TICK_BITS)
) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .nib_tick      (nib_tick),
  .full_duplex   (full_duplex),
  .gap_bytes     (gap_bytes),
  .tx_begin      (tx_begin),
  .tx_done       (tx_done),
  .carrier_sense (carrier_sense),
  .backoff_done  (backoff_done),
  .tx_permit     (tx_permit)
);

// File: tb/test_tx_gap_defer.sv
module test_tx_gap_defer;

  logic       clk;
  logic       rst_n;
  logic       nib_tick;
  logic       full_duplex;
  logic [4:0] gap_bytes;
  logic       tx_begin;
  logic       tx_done;
  logic       carrier_sense;
  logic       backoff_done;
  logic       tx_permit;

  int errors = 0;
  int checks = 0;

  tx_gap_defer i_tx_gap_defer (
    .clk           (clk),
    .rst_n         (rst_n),
    .nib_tick      (nib_tick),
    .full_duplex   (full_duplex),
    .gap_bytes     (gap_bytes),
    .tx_begin      (tx_begin),
    .tx_done       (tx_done),
    .carrier_sense (carrier_sense),
    .backoff_done  (backoff_done),
    .tx_permit     (tx_permit)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: tx_permit=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      nib_tick = 1'b1; cyc();
      nib_tick = 1'b0; cyc();
    end
  endtask

  task automatic pulse_begin();
    tx_begin = 1'b1; cyc(); tx_begin = 1'b0;
  endtask

  task automatic pulse_done();
    tx_done = 1'b1; cyc(); tx_done = 1'b0;
  endtask

  function automatic int exp_ticks(input int g);
    int c;
    c = (g < 8) ? 8 : ((g > 27) ? 27 : g);
    return 2 * c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; nib_tick = 1'b0; full_duplex = 1'b1; gap_bytes = 5'd12;
    tx_begin = 1'b0; tx_done = 1'b0; carrier_sense = 1'b0; backoff_done = 1'b1;
    repeat (3) cyc();
    check("R1 reset", tx_permit, 1'b0);
    rst_n = 1'b1;
    repeat (4) cyc();
    // R1: a full gap (24 ticks for setting 12) is needed after reset
    tick_n(23);
    check("R1 after reset 23 ticks", tx_permit, 1'b0);
    tick_n(1);
    check("R1 after reset 24 ticks", tx_permit, 1'b1);

    // Full-duplex sweep over every gap setting
    for (int g = 0; g < 32; g++) begin
      int t;
      string tag;
      t   = exp_ticks(g);
      tag = (g < 8) ? "R5" : ((g > 27) ? "R6" : "R4");
      pulse_begin();
      check("R2 begin clears", tx_permit, 1'b0);
      gap_bytes = 5'(g);
      tick_n(5);
      pulse_done();
      check("R3 ticks in frame ignored", tx_permit, 1'b0);
      if (g % 2 == 1) begin
        carrier_sense = 1'b1;   // R10
        backoff_done  = 1'b0;
      end
      tick_n(t - 1);
      check($sformatf("%s g=%0d one tick short", tag, g), tx_permit, 1'b0);
      tick_n(1);
      check($sformatf("%s g=%0d gap met", tag, g), tx_permit, 1'b1);
      if (g % 2 == 1) check("R10 carrier/backoff ignored", tx_permit, 1'b1);
      repeat (5) cyc();
      check("R11 permit holds", tx_permit, 1'b1);
      carrier_sense = 1'b0;
      backoff_done  = 1'b1;
    end

    // Half-duplex: restart after carrier returns at each idle count
    for (int k = 0; k < 24; k++) begin
      pulse_begin();
      check("R2 begin clears (half)", tx_permit, 1'b0);
      full_duplex   = 1'b0;
      carrier_sense = 1'b1;
      pulse_done();
      tick_n(3);
      carrier_sense = 1'b0;
      tick_n(k);
      carrier_sense = 1'b1;
      cyc();
      check("R8 carrier interrupts", tx_permit, 1'b0);
      tick_n(2);
      carrier_sense = 1'b0;
      backoff_done  = (k % 2 == 1);
      tick_n(23);
      check("R8 restart 23 ticks", tx_permit, 1'b0);
      tick_n(1);
      if (k % 2 == 0) begin
        check("R9 backoff pending", tx_permit, 1'b0);
        repeat (3) cyc();
        check("R9 backoff still pending", tx_permit, 1'b0);
        backoff_done = 1'b1;
        cyc();
        check("R9 backoff complete", tx_permit, 1'b1);
      end else begin
        check("R7 idle 24 ticks", tx_permit, 1'b1);
      end
      carrier_sense = 1'b1;
      cyc();
      check("R8 carrier defers", tx_permit, 1'b0);
      carrier_sense = 1'b0;
      tick_n(24);
      check("R7 idle regained", tx_permit, 1'b1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule